// File: doc/BRIEF.md
# Start-Stop Interval Gate

The block turns two event strobes, one marking a start and one marking a stop, into a gate pulse. The pulse is high for exactly the time between an accepted start and the stop that follows it. A true and an inverted copy of the pulse leave the block from two separate registers on the same clock edge. A downstream counter measures the width by counting while the gate is high. Counting is not part of this block.

Start and stop are synchronous single-cycle strobes sampled on the rising clock edge. Each one passes through its own capture stage. A stage sets once and then ignores further strobes until it is cleared. The asynchronous reset and the synchronous clear input both clear the two stages and arm the block. In single mode the block makes one pulse per arming. In averaging mode it re-arms itself after every stop while the measurement gate input stays high. It stops for good when that gate is seen low. The block streams no data, so every pin is a plain control or status signal with no handshake.

Top module: `interval_gate`

## Requirements
- R1: While rst_n is low and after it rises, with no strobe applied, pulse_o is 0, pulse_n_o is 1 and busy_o is 1.
- R2: When the block is armed and idle, a start strobe in cycle t makes pulse_o high from the edge that ends cycle t. A later stop strobe in cycle u makes pulse_o low from the edge that ends cycle u. The pulse therefore lasts u minus t clocks.
- R3: pulse_n_o is always the inverse of pulse_o.
- R4: A stop strobe that arrives while no start has been captured is ignored. It leaves pulse_o low and changes nothing else.
- R5: In single mode (avg_mode_i = 0) busy_o falls on the same edge as the pulse. After that, no start or stop produces a pulse until the block is armed again.
- R6: In averaging mode (avg_mode_i = 1) with gate_i high, both stages are re-armed on the clock after a stop is captured. A start in the cycle right after the stop strobe is ignored. A start from the following cycle onward begins a new pulse.
- R7: In averaging mode, a cycle with gate_i low and no clear makes busy_o and pulse_o low on the next edge, abandoning any pulse in progress. Both stay low until the block is armed again.
- R8: A start and a stop in the same cycle while armed and idle form a zero-length interval. pulse_o stays low, and the pair counts as complete: busy_o falls in single mode, and the block re-arms in averaging mode.
- R9: Start strobes that arrive while a pulse is high are ignored. They neither end nor restart it.
- R10: clr_i arms the block at any time. On the next edge busy_o is 1 and pulse_o is 0, and any strobe in the same cycle as the clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, leaves the block armed |
| clr_i | input | 1 | Synchronous clear and re-arm |
| start_i | input | 1 | Start event strobe |
| stop_i | input | 1 | Stop event strobe |
| gate_i | input | 1 | Measurement gate, used in averaging mode |
| avg_mode_i | input | 1 | 0 = single mode, 1 = averaging mode |
| pulse_o | output | 1 | Interval gate pulse |
| pulse_n_o | output | 1 | Inverted interval gate pulse |
| busy_o | output | 1 | Block armed or measuring |

## Verification
The bench sends a stop before any start. A design that lets it through would open a pulse or leave the stop stage set. It then strobes start again during a pulse and after a single-mode pulse ends. A design that misses the one-shot rule would restart the count or make a second pulse. In averaging mode the bench places a start in the dead cycle right after a stop, and another start in the cycle after that. An off-by-one re-arm would show as a pulse that starts one cycle early or not at all. It also applies a start and a stop in the same cycle, a clear that arrives together with a start, and a gate that closes in the middle of a pulse. Any of these handled wrongly would leave a stray pulse or a wrong busy level.

// File: rtl/interval_gate_pkg.sv
package interval_gate_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_AVG    = 1'b1
  } ig_mode_e;

  typedef struct packed {
    logic start_set;
    logic stop_set;
    logic clear;
  } ig_ctrl_t;
endpackage

// File: rtl/ig_capture.sv
module ig_capture #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set,
  output logic q,
  output logic q_next
);
  always_comb begin
    if (clear)    q_next = 1'b0;
    else if (set) q_next = 1'b1;
    else          q_next = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= q_next;
  end
endmodule

// File: rtl/ig_session.sv
module ig_session
  import interval_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     gate_i,
  input  ig_mode_e mode,
  input  logic     start_q,
  input  logic     stop_q,
  output ig_ctrl_t ctrl,
  output logic     busy
);
  logic gate_drop, rearm, live;

  assign gate_drop = (mode == MODE_AVG) && !gate_i && busy;
  assign rearm     = (mode == MODE_AVG) && gate_i && busy && stop_q;
  assign live      = busy && !gate_drop && !clr_i;

  always_comb begin
    ctrl.start_set = live && start_i && !start_q;
    ctrl.stop_set  = live && stop_i && !stop_q && (start_q || ctrl.start_set);
    ctrl.clear     = clr_i || gate_drop || rearm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     busy <= 1'b1;
    else if (clr_i)                                 busy <= 1'b1;
    else if (gate_drop)                             busy <= 1'b0;
    else if (mode == MODE_SINGLE && ctrl.stop_set)  busy <= 1'b0;
  end
endmodule

// File: rtl/ig_outstage.sv
module ig_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_next,
  output logic pulse_q,
  output logic pulse_nq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= 1'b0;
      pulse_nq <= 1'b1;
    end else begin
      pulse_q  <= pulse_next;
      pulse_nq <= ~pulse_next;
    end
  end
endmodule

// File: rtl/interval_gate.sv
module interval_gate
  import interval_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic gate_i,
  input  logic avg_mode_i,
  output logic pulse_o,
  output logic pulse_n_o,
  output logic busy_o
);
  localparam int NUM_STAGES = 2;

  ig_mode_e mode;
  ig_ctrl_t ctrl;
  logic [NUM_STAGES-1:0] stage_q, stage_next, stage_set;

  assign mode      = ig_mode_e'(avg_mode_i);
  assign stage_set = {ctrl.stop_set, ctrl.start_set};

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    ig_capture #(.RESET_VAL(1'b0)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (ctrl.clear),
      .set    (stage_set[g]),
      .q      (stage_q[g]),
      .q_next (stage_next[g])
    );
  end

  ig_session u_session (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .start_i (start_i),
    .stop_i  (stop_i),
    .gate_i  (gate_i),
    .mode    (mode),
    .start_q (stage_q[0]),
    .stop_q  (stage_q[1]),
    .ctrl    (ctrl),
    .busy    (busy_o)
  );

  ig_outstage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_next (stage_next[0] && !stage_next[1]),
    .pulse_q    (pulse_o),
    .pulse_nq   (pulse_n_o)
  );
endmodule

// File: rtl/interval_gate_checker.sv
module interval_gate_checker (
  input logic clk,
  input logic rst_n,
  input logic clr_i,
  input logic start_i,
  input logic stop_i,
  input logic gate_i,
  input logic avg_mode_i,
  input logic pulse_o,
  input logic pulse_n_o,
  input logic busy_o
);
  assert_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o == !pulse_n_o);

  assert_rise_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(start_i));

  assert_lone_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_o && stop_i && !start_i) |=> !pulse_o);

  assert_idle_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !clr_i) |=> (!busy_o && !pulse_o));

  assert_gate_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_mode_i && !gate_i && !clr_i) |=> (!busy_o && !pulse_o));

  assert_clear_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (busy_o && !pulse_o));
endmodule

bind interval_gate interval_gate_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .gate_i     (gate_i),
  .avg_mode_i (avg_mode_i),
  .pulse_o    (pulse_o),
  .pulse_n_o  (pulse_n_o),
  .busy_o     (busy_o)
);

// File: tb/tb_interval_gate.sv
module tb_interval_gate;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, clr_i, start_i, stop_i, gate_i, avg_mode_i;
  logic pulse_o, pulse_n_o, busy_o;

  int checks = 0;
  int errors = 0;

  bit m_busy, m_in, m_pair;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_gate dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i),
    .stop_i(stop_i), .gate_i(gate_i), .avg_mode_i(avg_mode_i),
    .pulse_o(pulse_o), .pulse_n_o(pulse_n_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    check(req, "pulse_o", pulse_o, m_in);
    check({req, "/R3"}, "pulse_n_o", pulse_n_o, !m_in);
    check(req, "busy_o", busy_o, m_busy);
  endtask

  task automatic model(input bit s, input bit p, input bit c, input bit g, input bit a);
    if (c) begin
      m_busy = 1; m_in = 0; m_pair = 0;
    end else if (!m_busy) begin
      // finished: nothing is accepted
    end else if (a && !g) begin
      m_busy = 0; m_in = 0; m_pair = 0;
    end else if (m_pair) begin
      m_pair = 0;
    end else if (!m_in) begin
      if (s && p) begin
        m_pair = 1;
        if (!a) m_busy = 0;
      end else if (s) begin
        m_in = 1;
      end
    end else if (p) begin
      m_in = 0; m_pair = 1;
      if (!a) m_busy = 0;
    end
  endtask

  task automatic step(input string req, input bit s, input bit p, input bit c,
                      input bit g, input bit a);
    @(negedge clk);
    compare(req);
    start_i = s; stop_i = p; clr_i = c; gate_i = g; avg_mode_i = a;
    model(s, p, c, g, a);
  endtask

  task automatic idle(input string req, input int n, input bit g, input bit a);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, g, a);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; clr_i = 0; start_i = 0; stop_i = 0; gate_i = 0; avg_mode_i = 0;
    m_busy = 1; m_in = 0; m_pair = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    idle("R1", 3, 0, 0);

    // R4: stop with nothing captured
    step("R4", 0, 1, 0, 0, 0);
    idle("R4", 2, 0, 0);

    // R2 width 4, R9 extra start inside the pulse
    step("R2", 1, 0, 0, 0, 0);
    idle("R2", 1, 0, 0);
    step("R9", 1, 0, 0, 0, 0);
    idle("R2", 1, 0, 0);
    step("R2", 0, 1, 0, 0, 0);
    idle("R5", 2, 0, 0);
    // R5: further strobes ignored in single mode
    step("R5", 1, 0, 0, 0, 0);
    idle("R5", 2, 0, 0);
    step("R5", 0, 1, 0, 0, 0);
    idle("R5", 2, 0, 0);

    // R10: clear together with a start
    step("R10", 1, 0, 1, 0, 0);
    idle("R10", 2, 0, 0);
    // R8: zero-length interval in single mode
    step("R8", 1, 1, 0, 0, 0);
    idle("R8", 3, 0, 0);
    step("R8", 1, 0, 0, 0, 0);
    idle("R8", 2, 0, 0);

    // averaging mode
    step("R10", 0, 0, 1, 1, 1);
    idle("R6", 1, 1, 1);
    step("R6", 1, 0, 0, 1, 1);
    idle("R6", 2, 1, 1);
    step("R6", 0, 1, 0, 1, 1);
    step("R6", 1, 0, 0, 1, 1);   // dead cycle, ignored
    step("R6", 1, 0, 0, 1, 1);   // accepted
    step("R6", 0, 1, 0, 1, 1);   // width 1
    idle("R6", 2, 1, 1);
    step("R8", 1, 1, 0, 1, 1);
    idle("R8", 2, 1, 1);
    step("R6", 1, 0, 0, 1, 1);
    idle("R6", 4, 1, 1);
    step("R6", 0, 1, 0, 1, 1);
    idle("R6", 2, 1, 1);
    // R7: gate closes mid pulse
    step("R7", 1, 0, 0, 1, 1);
    idle("R7", 2, 1, 1);
    step("R7", 0, 0, 0, 0, 1);
    idle("R7", 2, 0, 1);
    step("R7", 1, 0, 0, 1, 1);
    idle("R7", 2, 1, 1);
    step("R7", 0, 1, 0, 1, 1);
    idle("R7", 2, 1, 1);
    // R10: re-arm while gate is high
    step("R10", 0, 0, 1, 1, 1);
    step("R2", 1, 0, 0, 1, 1);
    idle("R2", 2, 1, 1);
    step("R2", 0, 1, 0, 1, 1);
    idle("R2", 2, 1, 1);
    @(negedge clk);
    compare("R6");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule